// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a keyboard input peripheral that sits on a 16-bit memory-mapped bus. On its device side a one-cycle strobe delivers a byte-wide character. The port holds that character and raises a ready flag. Until software reads the character, every further strobe is thrown away.

Software can work in two ways. It can poll the status word until the ready flag reads 1 and then read the data word. It can also set an interrupt-enable bit and wait for the level interrupt, which stays high while a character is pending and the enable bit is set. Reading the data word consumes the character: the ready flag drops and capture is armed again.

All outputs come from registers. Read data appears on `bus_rdata` in the cycle after the read strobe. In every other cycle `bus_rdata` is zero.

Top module: `kbd_port`

## Requirements
- R1: After a synchronous reset the ready flag is 0, the interrupt enable is 0, the held character is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: When the ready flag is 0, a `key_strobe` stores `key_char` and sets the ready flag at that clock edge. The status word at address 0xFE00 carries the ready flag in bit 15.
- R3: A read of the data word at address 0xFE02 returns the held character in bits 7:0 and zero in bits 15:8. Read data appears on `bus_rdata` in the cycle after `bus_rd` is high.
- R4: While the ready flag is 1, a `key_strobe` is discarded. The held character and the ready flag do not change.
- R5: A read of the data word clears the ready flag at that clock edge, and the next strobe is captured.
- R6: A write to the status word updates only the interrupt enable, which is status bit 14 and is taken from `bus_wdata[14]`. The ready flag cannot be written. A status read returns the ready flag in bit 15, the interrupt enable in bit 14, and zero in bits 13:0.
- R7: Writes to the data word are ignored, and the held character is unchanged.
- R8: `irq` is 1 exactly when both the ready flag and the interrupt enable are 1, in the same cycle as those flags.
- R9: If a strobe and a data-word read fall in the same cycle, the read returns the old character. The new character is then stored, and the ready flag stays 1.
- R10: A read of any address other than 0xFE00 or 0xFE02 returns zero and changes no state. In a cycle that follows no read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| key_strobe | input | 1 | Character-available pulse from the keyboard side |
| key_char | input | 8 | Character that goes with `key_strobe` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that the lock-out holds while a character is pending. They also check that capture and clear take effect at the correct edge, including the case where a read and a strobe coincide. On every cycle they confirm that the enable bit moves only on a status write, that `irq` follows ready AND enable, and that unmapped reads and data reads return zero in the bits they must.

Only the bench scenarios show the following. Every one of the 256 character values makes the round trip unchanged. A blocked strobe's character is truly lost. The read returns the old character in the race case. A sweep of addresses around the two registers neither returns data nor consumes a pending character.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } kbd_sel_e;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode
  import kbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output kbd_sel_e          sel,
  output logic              rd_stat,
  output logic              rd_data,
  output logic              wr_stat
);
  always_comb begin
    if (addr == STAT_ADDR)      sel = SEL_STAT;
    else if (addr == DATA_ADDR) sel = SEL_DATA;
    else                        sel = SEL_NONE;
  end

  assign rd_stat = rd && (sel == SEL_STAT);
  assign rd_data = rd && (sel == SEL_DATA);
  assign wr_stat = wr && (sel == SEL_STAT);
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [CHAR_W-1:0] chr,
  input  logic              consume,
  output logic              ready_q,
  output logic              ready_d,
  output logic [CHAR_W-1:0] char_q
);
  logic armed;
  logic take;

  // A same-cycle read frees the slot before the strobe is judged.
  assign armed   = !ready_q || consume;
  assign take    = strobe && armed;
  assign ready_d = take ? 1'b1 : (consume ? 1'b0 : ready_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      if (take) char_q <= chr;
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && strobe) |=> (ready_q && char_q == $past(chr)));
  p_lockout_r4: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !consume) |=> (ready_q && $stable(char_q)));
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (consume && !strobe) |=> !ready_q);
  p_race_r9: assert property (@(posedge clk) disable iff (rst)
    (consume && strobe) |=> (ready_q && char_q == $past(chr)));
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl #(
  parameter int DATA_W = 16,
  parameter int IE_BIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready_q,
  input  logic              ready_d,
  output logic              ie_q,
  output logic              irq
);
  logic ie_d;

  assign ie_d = wr_stat ? wdata[IE_BIT] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      ie_q <= ie_d;
      irq  <= ie_d && ready_d;
    end
  end

  p_ie_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> $stable(ie_q));
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (ready_q && ie_q));
endmodule

// File: rtl/kbd_readback.sv
module kbd_readback #(
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              ready_q,
  input  logic              ie_q,
  input  logic [CHAR_W-1:0] char_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] data_word;
  logic [DATA_W-1:0] next_word;

  always_comb begin
    stat_word            = '0;
    stat_word[READY_BIT] = ready_q;
    stat_word[IE_BIT]    = ie_q;
    data_word            = '0;
    data_word[CHAR_W-1:0] = char_q;
    if (rd_stat)      next_word = stat_word;
    else if (rd_data) next_word = data_word;
    else              next_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= next_word;
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> (rdata[DATA_W-1:CHAR_W] == '0));
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd || (!rd_stat && !rd_data)) |=> (rdata == '0));
endmodule

// File: rtl/kbd_port.sv
module kbd_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_strobe,
  input  logic [CHAR_W-1:0] key_char,
  output logic              irq
);
  import kbd_pkg::*;

  kbd_sel_e          sel;
  logic              rd_stat, rd_data, wr_stat;
  logic              ready_q, ready_d, ie_q;
  logic [CHAR_W-1:0] char_q;

  kbd_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel),
    .rd_stat(rd_stat), .rd_data(rd_data), .wr_stat(wr_stat)
  );

  kbd_capture #(.CHAR_W(CHAR_W)) u_cap (
    .clk(clk), .rst(rst), .strobe(key_strobe), .chr(key_char),
    .consume(rd_data), .ready_q(ready_q), .ready_d(ready_d), .char_q(char_q)
  );

  kbd_ctrl #(.DATA_W(DATA_W), .IE_BIT(IE_BIT)) u_ctl (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .wdata(bus_wdata),
    .ready_q(ready_q), .ready_d(ready_d), .ie_q(ie_q), .irq(irq)
  );

  kbd_readback #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .READY_BIT(READY_BIT), .IE_BIT(IE_BIT)) u_rb (
    .clk(clk), .rst(rst), .rd(bus_rd), .rd_stat(rd_stat), .rd_data(rd_data),
    .ready_q(ready_q), .ie_q(ie_q), .char_q(char_q), .rdata(bus_rdata)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !irq));
endmodule

// File: tb/sim_kbd_port.sv
module sim_kbd_port;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_DATA = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        key_strobe = 1'b0;
  logic [7:0]  key_char = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  kbd_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_strobe(key_strobe),
    .key_char(key_char), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Inputs change at negedge; registered results are sampled at the next negedge.
  task automatic rd_word(input logic [15:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wr_word(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    key_char = c; key_strobe = 1'b1;
    @(negedge clk);
    key_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v;
    logic        ie;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd_word(A_STAT, v); check("R1 status", v, 16'h0000);
    rd_word(A_DATA, v); check("R1 data", v, 16'h0000);

    // R2/R3/R5/R8: every character, with enable off then on
    for (int pass = 0; pass < 2; pass++) begin
      ie = pass[0];
      wr_word(A_STAT, ie ? 16'hFFFF : 16'h0000);
      for (int c = 0; c < 256; c++) begin
        key(c[7:0]);
        check("R8 irq set", {15'd0, irq}, {15'd0, ie});
        rd_word(A_STAT, v); check("R2 status ready", v, {1'b1, ie, 14'd0});
        rd_word(A_DATA, v); check("R3 data value", v, {8'd0, c[7:0]});
        check("R8 irq cleared", {15'd0, irq}, 16'h0000);
        rd_word(A_STAT, v); check("R5 ready cleared", v, {1'b0, ie, 14'd0});
      end
    end

    // R6: only bit 14 writable, ready not writable
    wr_word(A_STAT, 16'hBFFF);
    rd_word(A_STAT, v); check("R6 write all but ie", v, 16'h0000);
    wr_word(A_STAT, 16'h4000);
    rd_word(A_STAT, v); check("R6 ie only", v, 16'h4000);
    check("R8 no irq without ready", {15'd0, irq}, 16'h0000);

    // R4: lockout while pending
    key(8'h41);
    key(8'h42);
    key(8'h43);
    rd_word(A_DATA, v); check("R4 first kept", v, 16'h0041);
    rd_word(A_STAT, v); check("R4 later strobes dropped", v, 16'h4000);
    key(8'h44);
    rd_word(A_DATA, v); check("R5 recaptured", v, 16'h0044);

    // R7: data writes ignored
    key(8'h5A);
    wr_word(A_DATA, 16'hFFA5);
    rd_word(A_STAT, v); check("R7 ready after data write", v, 16'hC000);
    rd_word(A_DATA, v); check("R7 char after data write", v, 16'h005A);

    // R9: race of read and strobe
    key(8'h11);
    bus_addr = A_DATA; bus_rd = 1'b1; key_char = 8'h22; key_strobe = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; key_strobe = 1'b0;
    check("R9 old char returned", bus_rdata, 16'h0011);
    check("R9 irq stays", {15'd0, irq}, 16'h0001);
    rd_word(A_STAT, v); check("R9 ready stays", v, 16'hC000);
    rd_word(A_DATA, v); check("R9 new char", v, 16'h0022);

    // R10: address sweep with a pending character
    key(8'h77);
    for (int a = 16'hFD00; a < 16'hFF00; a++) begin
      if (a[15:0] != A_STAT && a[15:0] != A_DATA) begin
        rd_word(a[15:0], v); check("R10 unmapped zero", v, 16'h0000);
      end
    end
    rd_word(16'h0000, v); check("R10 addr 0", v, 16'h0000);
    rd_word(16'hFFFF, v); check("R10 addr ffff", v, 16'h0000);
    @(negedge clk);
    check("R10 idle zero", bus_rdata, 16'h0000);
    rd_word(A_DATA, v); check("R10 no state change", v, 16'h0077);

    // R1 again: reset from a busy state
    key(8'h99);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {15'd0, irq}, 16'h0000);
    rd_word(A_STAT, v); check("R1 status after reset", v, 16'h0000);
    rd_word(A_DATA, v); check("R1 data after reset", v, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule